// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the 16-bit time-base count that a two-channel PWM generator compares against. The system clock first passes through two cascaded dividers. Together they form a prescaled tick. On each tick the counter advances according to the selected counting mode, unless the run control holds it.

Both PWM channels share one period value. That value is written either straight into the active register or into a shadow copy. The shadow copy is transferred when the counter next enters zero.

Two single-clock event strobes go to a downstream action qualifier. One marks the counter entering zero. The other marks the counter reaching the active period. The block also reports the current counting direction.

Top module: `pwm_timebase`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the count, both prescaler stages, the active and shadow period and both event strobes, and sets `dir_up` to 1.
- R2: With `hs_div` = h and `ck_div` = c, held constant since reset, the prescale factor is D = (h==0 ? 1 : 2h) * 2^c. The count can advance only on every D-th clock, in clock cycles D-1, 2D-1, ... counted from the first cycle after reset.
- R3: `ctr_mode` = 0 (up): each advance adds 1. When the count is greater than or equal to the active period it wraps to 0. `dir_up` reads 1.
- R4: `ctr_mode` = 1 (down): each advance subtracts 1. From 0 the count reloads the active period. `dir_up` reads 0.
- R5: `ctr_mode` = 2 (up-down): while rising, a count at or above the period turns the direction to falling and steps down by 1. At 0 it stays 0. While falling, a count of 0 turns the direction to rising and steps to 1. With a period of 0 it stays 0.
- R6: `ctr_mode` = 3 (freeze): the count and direction hold and no event strobe fires.
- R7: `run_mode` = 0 holds the count. `run_mode` = 1 lets the count advance only while it is non-zero, so a cycle in progress finishes at 0 and stays there. `run_mode` = 2 and 3 run freely.
- R8: A period write (`prd_wr`) with `prd_imm` = 1 loads `prd_wdata` into both the active and the shadow period. It takes effect on the next clock.
- R9: A period write with `prd_imm` = 0 loads only the shadow period. The shadow copy moves into the active period on the advance that makes the count 0.
- R10: `zero_evt` and `prd_evt` are high for one clock, in the cycle after an advance. `zero_evt` fires when the new count is 0. `prd_evt` fires when the new count equals the active period in force before that advance. Neither fires without an advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctr_mode | input | 2 | 0 up, 1 down, 2 up-down, 3 freeze |
| run_mode | input | 2 | 0 halt, 1 finish cycle, 2/3 free run |
| prd_imm | input | 1 | 1: period write goes to active period at once; 0: through shadow |
| hs_div | input | 3 | First prescaler stage select |
| ck_div | input | 3 | Second prescaler stage select (power of two) |
| prd_wr | input | 1 | Period write strobe |
| prd_wdata | input | 16 | Period write data |
| count | output | 16 | Time-base count |
| dir_up | output | 1 | 1 while counting up |
| zero_evt | output | 1 | Counter-entered-zero strobe |
| prd_evt | output | 1 | Counter-reached-period strobe |

## Verification
A prescaler that slips by even one clock moves the first count change away from cycle D-1. That shows on `count` within one prescale period after reset. A corrupted direction bit or period copy in up-down or down mode shows as a wrong count at the next turn-around, within one period of ticks. A shadow period transferred at the wrong moment shows at the first wrap after the write, as a wrap at the wrong value and a misplaced `prd_evt`. A cycle-by-cycle reference model compares every output on every clock, so each of these errors is reported in the cycle it first appears.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
    typedef enum logic [1:0] {
        CM_UP   = 2'd0,
        CM_DOWN = 2'd1,
        CM_UPDN = 2'd2,
        CM_HOLD = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RM_HALT   = 2'd0,
        RM_FINISH = 2'd1,
        RM_FREE_A = 2'd2,
        RM_FREE_B = 2'd3
    } run_mode_e;
endpackage

// File: rtl/pwmtb_prescaler.sv
module pwmtb_prescaler #(
    parameter int HS_W = 3,
    parameter int CK_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HS_W-1:0] hs_sel,
    input  logic [CK_W-1:0] ck_sel,
    output logic            tick
);
    localparam int HS_CW = HS_W + 2;
    localparam int CK_CW = 2 ** CK_W;

    typedef struct packed {
        logic [HS_CW-1:0] hs;
        logic [CK_CW-1:0] ck;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [HS_CW-1:0] hs_lim;
    logic [CK_CW-1:0] ck_lim;
    logic             hs_wrap;

    always_comb begin
        hs_lim  = (hs_sel == '0) ? '0 : HS_CW'({hs_sel, 1'b0}) - HS_CW'(1);
        ck_lim  = (CK_CW'(1) << ck_sel) - CK_CW'(1);
        hs_wrap = (st_q.hs >= hs_lim);
        tick    = hs_wrap && (st_q.ck >= ck_lim);
        st_d    = st_q;
        st_d.hs = hs_wrap ? '0 : st_q.hs + HS_CW'(1);
        if (tick)         st_d.ck = '0;
        else if (hs_wrap) st_d.ck = st_q.ck + CK_CW'(1);
        if (rst)          st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;
endmodule

// File: rtl/pwmtb_period.sv
module pwmtb_period #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          imm,
    input  logic [CW-1:0] wdata,
    input  logic          xfer,
    output logic [CW-1:0] act
);
    typedef struct packed {
        logic [CW-1:0] act;
        logic [CW-1:0] shd;
    } prd_st_t;

    prd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (xfer) st_d.act = st_q.shd;
        if (wr) begin
            st_d.shd = wdata;
            if (imm) st_d.act = wdata;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign act = st_q.act;
endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
    import pwmtb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [1:0]    mode,
    input  logic [1:0]    run,
    input  logic [CW-1:0] prd,
    output logic [CW-1:0] count,
    output logic          dir_up,
    output logic          zero_evt,
    output logic          prd_evt,
    output logic          xfer
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          dir;
        logic          zev;
        logic          pev;
    } cnt_st_t;

    cnt_st_t       st_d, st_q;
    logic [CW-1:0] nxt_cnt;
    logic          nxt_dir;
    logic          advance;
    logic          run_ok;

    always_comb begin
        run_ok  = run[1] || ((run == RM_FINISH) && (st_q.cnt != '0));
        advance = tick && (mode != CM_HOLD) && run_ok;
        nxt_cnt = st_q.cnt;
        nxt_dir = st_q.dir;
        case (cnt_mode_e'(mode))
            CM_UP: begin
                nxt_dir = 1'b1;
                nxt_cnt = (st_q.cnt >= prd) ? '0 : st_q.cnt + CW'(1);
            end
            CM_DOWN: begin
                nxt_dir = 1'b0;
                nxt_cnt = (st_q.cnt == '0) ? prd : st_q.cnt - CW'(1);
            end
            CM_UPDN: begin
                if (st_q.dir) begin
                    if (st_q.cnt >= prd) begin
                        nxt_dir = 1'b0;
                        nxt_cnt = (st_q.cnt == '0) ? '0 : st_q.cnt - CW'(1);
                    end else begin
                        nxt_cnt = st_q.cnt + CW'(1);
                    end
                end else begin
                    if (st_q.cnt == '0) begin
                        nxt_dir = 1'b1;
                        nxt_cnt = (prd == '0) ? '0 : CW'(1);
                    end else begin
                        nxt_cnt = st_q.cnt - CW'(1);
                    end
                end
            end
            default: begin
                nxt_cnt = st_q.cnt;
                nxt_dir = st_q.dir;
            end
        endcase

        xfer     = advance && (nxt_cnt == '0);
        st_d     = st_q;
        st_d.zev = advance && (nxt_cnt == '0);
        st_d.pev = advance && (nxt_cnt == prd);
        if (advance) begin
            st_d.cnt = nxt_cnt;
            st_d.dir = nxt_dir;
        end
        if (rst) begin
            st_d     = '0;
            st_d.dir = 1'b1;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign count    = st_q.cnt;
    assign dir_up   = st_q.dir;
    assign zero_evt = st_q.zev;
    assign prd_evt  = st_q.pev;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CW   = 16,
    parameter int HS_W = 3,
    parameter int CK_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      ctr_mode,
    input  logic [1:0]      run_mode,
    input  logic            prd_imm,
    input  logic [HS_W-1:0] hs_div,
    input  logic [CK_W-1:0] ck_div,
    input  logic            prd_wr,
    input  logic [CW-1:0]   prd_wdata,
    output logic [CW-1:0]   count,
    output logic            dir_up,
    output logic            zero_evt,
    output logic            prd_evt
);
    logic          tick;
    logic          xfer;
    logic [CW-1:0] prd_act;

    pwmtb_prescaler #(.HS_W(HS_W), .CK_W(CK_W)) u_pre (
        .clk(clk), .rst(rst), .hs_sel(hs_div), .ck_sel(ck_div), .tick(tick)
    );

    pwmtb_period #(.CW(CW)) u_prd (
        .clk(clk), .rst(rst), .wr(prd_wr), .imm(prd_imm),
        .wdata(prd_wdata), .xfer(xfer), .act(prd_act)
    );

    pwmtb_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .mode(ctr_mode), .run(run_mode),
        .prd(prd_act), .count(count), .dir_up(dir_up),
        .zero_evt(zero_evt), .prd_evt(prd_evt), .xfer(xfer)
    );
endmodule

// File: rtl/pwm_timebase_checker.sv
module pwm_timebase_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    ctr_mode,
    input logic [1:0]    run_mode,
    input logic [CW-1:0] count,
    input logic          zero_evt,
    input logic          prd_evt,
    input logic [CW-1:0] prd_act
);
    assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (ctr_mode == 2'd3) |=> ($stable(count) && !zero_evt && !prd_evt));

    assert_halt_R7: assert property (@(posedge clk) disable iff (rst)
        (run_mode == 2'd0) |=> $stable(count));

    assert_zero_evt_R10: assert property (@(posedge clk) disable iff (rst)
        zero_evt |-> (count == '0));

    assert_up_step_R3: assert property (@(posedge clk) disable iff (rst)
        (ctr_mode == 2'd0 && count < prd_act) |=>
        (count == $past(count) + CW'(1) || $stable(count)));

    assert_down_step_R4: assert property (@(posedge clk) disable iff (rst)
        (ctr_mode == 2'd1 && count != '0) |=>
        (count == $past(count) - CW'(1) || $stable(count)));
endmodule

bind pwm_timebase pwm_timebase_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .ctr_mode(ctr_mode), .run_mode(run_mode),
    .count(count), .zero_evt(zero_evt), .prd_evt(prd_evt), .prd_act(prd_act)
);

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ctr_mode = 2'd0;
    logic [1:0]  run_mode = 2'd3;
    logic        prd_imm = 1'b1;
    logic [2:0]  hs_div = 3'd0;
    logic [2:0]  ck_div = 3'd0;
    logic        prd_wr = 1'b0;
    logic [15:0] prd_wdata = 16'd0;
    logic [15:0] count;
    logic        dir_up, zero_evt, prd_evt;

    int n_run = 0;
    int n_fail = 0;

    // reference model state
    int          m_pre = 0;
    logic [15:0] m_cnt = 0, m_act = 0, m_shd = 0;
    logic        m_dir = 1'b1, m_zev = 1'b0, m_pev = 1'b0;

    always #2 clk = ~clk;

    pwm_timebase u_pwm_timebase (
        .clk(clk), .rst(rst), .ctr_mode(ctr_mode), .run_mode(run_mode),
        .prd_imm(prd_imm), .hs_div(hs_div), .ck_div(ck_div),
        .prd_wr(prd_wr), .prd_wdata(prd_wdata), .count(count),
        .dir_up(dir_up), .zero_evt(zero_evt), .prd_evt(prd_evt)
    );

    function automatic int pscale(logic [2:0] h, logic [2:0] c);
        return ((h == 0) ? 1 : 2 * int'(h)) * (1 << c);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        int          np;
        logic        tk, adv;
        logic [15:0] nc, na, ns;
        logic        nd, nz, npv;
        if (rst) begin
            np = 0; nc = 0; nd = 1'b1; nz = 0; npv = 0; na = 0; ns = 0;
        end else begin
            tk = (m_pre == pscale(hs_div, ck_div) - 1);
            np = tk ? 0 : m_pre + 1;
            adv = tk && ctr_mode != 2'd3 && (run_mode[1] || (run_mode == 2'd1 && m_cnt != 0));
            nc = m_cnt; nd = m_dir;
            if (ctr_mode == 2'd0) begin
                nd = 1'b1; nc = (m_cnt >= m_act) ? 16'd0 : m_cnt + 16'd1;
            end else if (ctr_mode == 2'd1) begin
                nd = 1'b0; nc = (m_cnt == 0) ? m_act : m_cnt - 16'd1;
            end else if (ctr_mode == 2'd2) begin
                if (m_dir) begin
                    if (m_cnt >= m_act) begin nd = 1'b0; nc = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1; end
                    else nc = m_cnt + 16'd1;
                end else begin
                    if (m_cnt == 0) begin nd = 1'b1; nc = (m_act == 0) ? 16'd0 : 16'd1; end
                    else nc = m_cnt - 16'd1;
                end
            end
            nz  = adv && nc == 0;
            npv = adv && nc == m_act;
            na = m_act; ns = m_shd;
            if (adv && nc == 0) na = m_shd;
            if (prd_wr) begin ns = prd_wdata; if (prd_imm) na = prd_wdata; end
            if (!adv) begin nc = m_cnt; nd = m_dir; end
        end
        @(posedge clk);
        m_pre = np; m_cnt = nc; m_dir = nd; m_zev = nz; m_pev = npv; m_act = na; m_shd = ns;
        @(negedge clk);
        chk(tag, "count", int'(count), int'(m_cnt));
        chk(tag, "dir_up", int'(dir_up), int'(m_dir));
        chk("R10", "zero_evt", int'(zero_evt), int'(m_zev));
        chk("R10", "prd_evt", int'(prd_evt), int'(m_pev));
    endtask

    task automatic run_n(string tag, int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic do_reset(logic [2:0] h, logic [2:0] c);
        rst = 1'b1; hs_div = h; ck_div = c; prd_wr = 1'b0;
        run_n("R1", 2);
        rst = 1'b0;
    endtask

    task automatic wr_prd(logic [15:0] v, logic imm, string tag);
        prd_wr = 1'b1; prd_wdata = v; prd_imm = imm;
        step(tag);
        prd_wr = 1'b0;
    endtask

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset(3'd0, 3'd0);
        // R1: reset state, counter quiet
        chk("R1", "count_after_reset", int'(count), 0);
        chk("R1", "dir_after_reset", int'(dir_up), 1);
        // R8 immediate load, then R3 up counting with wrap
        ctr_mode = 2'd0; run_mode = 2'd3;
        wr_prd(16'd4, 1'b1, "R8");
        run_n("R3", 12);
        ctr_mode = 2'd1; run_n("R4", 12);
        ctr_mode = 2'd2; run_n("R5", 20);
        ctr_mode = 2'd3; run_n("R6", 6);
        ctr_mode = 2'd0; run_mode = 2'd0; run_n("R7", 6);
        run_mode = 2'd1; run_n("R7", 10);
        chk("R7", "finish_at_zero", int'(count), 0);
        run_mode = 2'd2; run_n("R7", 6);
        // R9 shadow load lands at next zero
        run_mode = 2'd3;
        wr_prd(16'd7, 1'b0, "R9");
        run_n("R9", 20);
        // period 0 and period 0xFFFF corners
        wr_prd(16'd0, 1'b1, "R8");
        run_n("R3", 4);
        ctr_mode = 2'd2; run_n("R5", 4);
        ctr_mode = 2'd1; wr_prd(16'hFFFF, 1'b1, "R8");
        run_n("R4", 6);
        // R2 prescaler 6 * 4 = 24
        do_reset(3'd3, 3'd2);
        ctr_mode = 2'd0; run_mode = 2'd3;
        wr_prd(16'd9, 1'b1, "R2");
        run_n("R2", 22);
        chk("R2", "before_first_tick", int'(count), 0);
        step("R2");
        chk("R2", "first_tick_cycle", int'(count), 1);
        run_n("R2", 100);
        // constrained random segments
        for (int s = 0; s < 20; s++) begin
            do_reset(3'($urandom_range(0, 2)), 3'($urandom_range(0, 2)));
            for (int i = 0; i < 300; i++) begin
                if ($urandom_range(0, 15) == 0) ctr_mode = 2'($urandom_range(0, 3));
                if ($urandom_range(0, 23) == 0) run_mode = 2'($urandom_range(0, 3));
                prd_wr = ($urandom_range(0, 19) == 0);
                prd_imm = 1'($urandom_range(0, 1));
                prd_wdata = 16'($urandom_range(0, 12));
                step(mode_tag(ctr_mode));
            end
            prd_wr = 1'b0;
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule